// File: doc/BRIEF.md
# UART Receive Holding Buffer with Overflow Tagging

This block sits between a UART's bit-level receiver and the register interface software reads. A finished character arrives as a one-cycle pulse with its data byte and two error tags: frame error (the first stop bit was sampled low) and parity error. It is kept in a two-entry first-in first-out holding buffer. When that buffer is full, one more character can wait in a single-entry stage that stands in for the receive shift register. Software reads the oldest character through a read strobe. The error tags it sees always belong to the character it is about to read, not to the one most recently received.

An overflow is declared only when three things are true together: the holding buffer is full, a finished character is waiting, and the receiver reports a new start bit. From then on, arriving characters are thrown away until software writes a one to clear the flag. Each read that frees a slot also moves the waiting character forward. Frame and parity errors do not stop reception: the tagged character is stored like any other. Every stored tagged character and every new overflow raises a one-cycle error pulse, which is meant for the shared error interrupt flag. Dropping the receive enable empties all storage and clears the overflow flag.

Top module: `rxhold_top`

## Requirements
- R1: After reset `not_empty`, `ovf_flag`, `err_pulse`, `rd_data`, `rd_ferr` and `rd_perr` are all 0.
- R2: Stored characters are read in arrival order. `not_empty` is 1 from the clock edge that stores the first character, and `rd_data` shows the oldest one. Each `rd_strobe` removes it at the next edge.
- R3: `ovf_flag` becomes 1 at the edge that samples `start_seen` while two characters are held, a third is waiting, and no read happens in that cycle. With only two characters stored, a start bit leaves the flag at 0.
- R4: While `ovf_flag` is 1, a `chr_done` character is discarded. It never appears at `rd_data`.
- R5: `rd_ferr` and `rd_perr` are the tags of the character shown at `rd_data`. After a read they show the tags of the next character.
- R6: A character with a frame or parity error is stored, and the characters after it are still accepted.
- R7: With `rx_en` at 0, the next edge empties all storage (`not_empty` = 0) and clears `ovf_flag`. While `rx_en` stays 0, `chr_done`, `start_seen` and `rd_strobe` have no effect.
- R8: A pulse on `ovf_clr` clears `ovf_flag` at the next edge. Without that pulse the flag stays set. If an overflow is detected in the same cycle as the clear, the flag stays 1.
- R9: `err_pulse` is 1 for exactly one cycle, at the edge after a tagged character is accepted or an overflow is detected. A clean character or a discarded character does not raise it.
- R10: A read with a character waiting moves that character into the buffer in the same edge, so it is read after the two older ones. A read while empty has no effect.
- R11: A character that arrives while the buffer is full and a character is already waiting, with no read in that cycle, is discarded even when no overflow is flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_en | input | 1 | Receiver enable. 0 flushes and holds all storage empty |
| chr_done | input | 1 | One-cycle pulse: a character is complete |
| chr_data | input | DW | Data of the completed character |
| chr_ferr | input | 1 | Frame error tag of the completed character |
| chr_perr | input | 1 | Parity error tag of the completed character |
| start_seen | input | 1 | One-cycle pulse: a new start bit was detected |
| rd_strobe | input | 1 | Data register read: removes the oldest character |
| ovf_clr | input | 1 | Write-one-to-clear pulse for the overflow flag |
| rd_data | output | DW | Oldest stored character, 0 when empty |
| rd_ferr | output | 1 | Frame error tag of the oldest character |
| rd_perr | output | 1 | Parity error tag of the oldest character |
| not_empty | output | 1 | At least one character is readable |
| ovf_flag | output | 1 | Overflow status flag |
| err_pulse | output | 1 | One-cycle error event for the shared interrupt flag |

## Verification
A wrong occupancy count or pointer shows up at the very next read: `rd_data` or its tags belong to the wrong character, or `not_empty` drops a character too early or too late. If the waiting stage is handled badly, the third character is lost or is read twice. That only shows once the two older characters have been read, which takes two reads after the fault. A fault in the overflow logic shows one edge after the start bit, as a wrong `ovf_flag` or a missing `err_pulse`. A character that should have been dropped but was stored is seen only when software reaches it in the read order.

// File: rtl/rxhold_pkg.sv
package rxhold_pkg;

  typedef struct packed {
    logic ferr;
    logic perr;
  } rx_tag_t;

  // circular index advance for a buffer of 'depth' slots
  function automatic int unsigned wrap_next(int unsigned idx, int unsigned depth);
    return (idx + 1 >= depth) ? 0 : idx + 1;
  endfunction

  // occupancy after one cycle of push/pop
  function automatic int unsigned occ_next(int unsigned occ, logic push, logic pop);
    int unsigned res;
    res = occ;
    if (push && !pop) res = occ + 1;
    else if (pop && !push) res = occ - 1;
    return res;
  endfunction

  function automatic logic tag_bad(rx_tag_t t);
    return t.ferr | t.perr;
  endfunction

endpackage

// File: rtl/rxhold_fifo.sv
module rxhold_fifo
  import rxhold_pkg::*;
#(
  parameter int DW    = 8,
  parameter int DEPTH = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  rx_tag_t       push_tag,
  input  logic          pop,
  output logic [DW-1:0] head_data,
  output rx_tag_t       head_tag,
  output logic          full,
  output logic          empty
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] occ_q;
  logic [DW-1:0]    data_arr [DEPTH];
  rx_tag_t          tag_arr  [DEPTH];

  genvar g;
  generate
    for (g = 0; g < DEPTH; g++) begin : g_slot
      logic [DW-1:0] slot_data;
      rx_tag_t       slot_tag;
      logic          slot_we;
      assign slot_we = push && (wr_ptr == PTR_W'(g));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          slot_data <= '0;
          slot_tag  <= '0;
        end else if (slot_we) begin
          slot_data <= push_data;
          slot_tag  <= push_tag;
        end
      end
      assign data_arr[g] = slot_data;
      assign tag_arr[g]  = slot_tag;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      occ_q  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      occ_q  <= '0;
    end else begin
      if (push) wr_ptr <= PTR_W'(wrap_next(32'(wr_ptr), DEPTH));
      if (pop)  rd_ptr <= PTR_W'(wrap_next(32'(rd_ptr), DEPTH));
      occ_q <= CNT_W'(occ_next(32'(occ_q), push, pop));
    end
  end

  assign head_data = data_arr[rd_ptr];
  assign head_tag  = tag_arr[rd_ptr];
  assign full      = (occ_q == CNT_W'(DEPTH));
  assign empty     = (occ_q == '0);

  // R11: a push never lands on a full buffer unless a slot is freed that cycle
  p_push_room_r11: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (!full || pop));
  // R10: a pop never happens on an empty buffer
  p_pop_nonempty_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);

endmodule

// File: rtl/rxhold_wait.sv
module rxhold_wait
  import rxhold_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          load,
  input  logic          unload,
  input  logic [DW-1:0] in_data,
  input  rx_tag_t       in_tag,
  output logic          valid,
  output logic [DW-1:0] out_data,
  output rx_tag_t       out_tag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid    <= 1'b0;
      out_data <= '0;
      out_tag  <= '0;
    end else if (flush) begin
      valid <= 1'b0;
    end else if (load) begin
      valid    <= 1'b1;
      out_data <= in_data;
      out_tag  <= in_tag;
    end else if (unload) begin
      valid <= 1'b0;
    end
  end

  // R10: the stage only empties through an unload or a flush
  p_wait_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !unload && !flush) |=> valid);

endmodule

// File: rtl/rxhold_status.sv
module rxhold_status (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_en,
  input  logic ovf_set,
  input  logic ovf_clr,
  input  logic tagged_accept,
  output logic ovf_flag,
  output logic err_pulse
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_flag  <= 1'b0;
      err_pulse <= 1'b0;
    end else if (!rx_en) begin
      ovf_flag  <= 1'b0;
      err_pulse <= 1'b0;
    end else begin
      if (ovf_set)      ovf_flag <= 1'b1;
      else if (ovf_clr) ovf_flag <= 1'b0;
      err_pulse <= ovf_set | tagged_accept;
    end
  end

  // R3: the flag only rises after a detected overflow condition
  p_ovf_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_flag) |-> $past(ovf_set));
  // R7: disabling the receiver clears the flag
  p_flush_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> !ovf_flag);
  // R8: a clear without a competing set empties the flag
  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en && ovf_clr && !ovf_set) |=> !ovf_flag);
  // R9: an overflow event is reported on the error pulse
  p_err_on_ovf_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en && ovf_set) |=> err_pulse);

endmodule

// File: rtl/rxhold_top.sv
module rxhold_top
  import rxhold_pkg::*;
#(
  parameter int DW         = 8,
  parameter int HOLD_DEPTH = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_en,
  input  logic          chr_done,
  input  logic [DW-1:0] chr_data,
  input  logic          chr_ferr,
  input  logic          chr_perr,
  input  logic          start_seen,
  input  logic          rd_strobe,
  input  logic          ovf_clr,
  output logic [DW-1:0] rd_data,
  output logic          rd_ferr,
  output logic          rd_perr,
  output logic          not_empty,
  output logic          ovf_flag,
  output logic          err_pulse
);
  rx_tag_t       in_tag, wait_tag, head_tag, push_tag;
  logic [DW-1:0] wait_data, head_data, push_data;
  logic          fifo_full, fifo_empty, wait_valid;

  // named internal events
  logic pop_fire, room, new_ok, accept_chr, drop_chr;
  logic direct_push, wait_load, wait_unload, push_fire;
  logic ovf_set, tagged_accept, flush;

  assign in_tag      = '{ferr: chr_ferr, perr: chr_perr};
  assign flush       = !rx_en;
  assign pop_fire    = rx_en && rd_strobe && !fifo_empty;
  assign room        = !fifo_full || pop_fire;
  assign new_ok      = rx_en && chr_done && !ovf_flag;
  assign wait_unload = rx_en && wait_valid && room;
  assign accept_chr  = new_ok && !(wait_valid && !room);
  assign drop_chr    = rx_en && chr_done && !accept_chr;
  assign direct_push = accept_chr && !wait_valid && room;
  assign wait_load   = accept_chr && !direct_push;
  assign push_fire   = wait_unload || direct_push;
  assign push_data   = wait_valid ? wait_data : chr_data;
  assign push_tag    = wait_valid ? wait_tag  : in_tag;
  assign ovf_set     = rx_en && start_seen && fifo_full && wait_valid && !pop_fire;
  assign tagged_accept = accept_chr && tag_bad(in_tag);

  rxhold_fifo #(.DW(DW), .DEPTH(HOLD_DEPTH)) fifo_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .push      (push_fire),
    .push_data (push_data),
    .push_tag  (push_tag),
    .pop       (pop_fire),
    .head_data (head_data),
    .head_tag  (head_tag),
    .full      (fifo_full),
    .empty     (fifo_empty)
  );

  rxhold_wait #(.DW(DW)) wait_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (flush),
    .load     (wait_load),
    .unload   (wait_unload),
    .in_data  (chr_data),
    .in_tag   (in_tag),
    .valid    (wait_valid),
    .out_data (wait_data),
    .out_tag  (wait_tag)
  );

  rxhold_status status_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .rx_en         (rx_en),
    .ovf_set       (ovf_set),
    .ovf_clr       (ovf_clr),
    .tagged_accept (tagged_accept),
    .ovf_flag      (ovf_flag),
    .err_pulse     (err_pulse)
  );

  assign not_empty = !fifo_empty;
  assign rd_data   = not_empty ? head_data     : '0;
  assign rd_ferr   = not_empty && head_tag.ferr;
  assign rd_perr   = not_empty && head_tag.perr;

  // R11: a waiting character exists only behind a full buffer
  p_wait_full_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wait_valid |-> fifo_full);
  // R4: nothing is accepted while the overflow flag is set
  p_no_accept_ovf_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && chr_done) |-> !accept_chr);
  // R11: a dropped character changes neither the buffer nor the waiting stage
  p_drop_no_store_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_chr && !pop_fire) |=> (wait_valid == $past(wait_valid)) && (fifo_full == $past(fifo_full)));
  // R2: storage never drains without a read or a flush
  p_no_silent_drain_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_empty && !pop_fire && rx_en) |=> !fifo_empty);

endmodule

// File: tb/rxhold_top_tb_top.sv
module rxhold_top_tb_top;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rx_en = 1'b1;
  logic          chr_done = 1'b0;
  logic [DW-1:0] chr_data = '0;
  logic          chr_ferr = 1'b0;
  logic          chr_perr = 1'b0;
  logic          start_seen = 1'b0;
  logic          rd_strobe = 1'b0;
  logic          ovf_clr = 1'b0;
  logic [DW-1:0] rd_data;
  logic          rd_ferr, rd_perr, not_empty, ovf_flag, err_pulse;

  int checks = 0;
  int errors = 0;
  logic finished = 1'b0;

  always #5 clk = ~clk;

  rxhold_top #(.DW(DW), .HOLD_DEPTH(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .chr_done(chr_done),
    .chr_data(chr_data), .chr_ferr(chr_ferr), .chr_perr(chr_perr),
    .start_seen(start_seen), .rd_strobe(rd_strobe), .ovf_clr(ovf_clr),
    .rd_data(rd_data), .rd_ferr(rd_ferr), .rd_perr(rd_perr),
    .not_empty(not_empty), .ovf_flag(ovf_flag), .err_pulse(err_pulse)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic send(input logic [DW-1:0] d, input logic f, input logic p);
    chr_data = d; chr_ferr = f; chr_perr = p; chr_done = 1'b1;
    @(negedge clk);
    chr_done = 1'b0; chr_ferr = 1'b0; chr_perr = 1'b0;
  endtask

  task automatic rd();
    rd_strobe = 1'b1;
    @(negedge clk);
    rd_strobe = 1'b0;
  endtask

  task automatic start_bit();
    start_seen = 1'b1;
    @(negedge clk);
    start_seen = 1'b0;
  endtask

  task automatic clear_ovf();
    ovf_clr = 1'b1;
    @(negedge clk);
    ovf_clr = 1'b0;
  endtask

  task automatic expect_head(input string req, input int d, input int f, input int p);
    chk(req, "not_empty", int'(not_empty), 1);
    chk(req, "rd_data", int'(rd_data), d);
    chk(req, "rd_ferr", int'(rd_ferr), f);
    chk(req, "rd_perr", int'(rd_perr), p);
  endtask

  task automatic drain_to_empty();
    for (int i = 0; i < 4; i++) if (not_empty) rd();
    if (ovf_flag) clear_ovf();
  endtask

  task automatic t_reset();
    chk("R1", "not_empty", int'(not_empty), 0);
    chk("R1", "ovf_flag", int'(ovf_flag), 0);
    chk("R1", "err_pulse", int'(err_pulse), 0);
    chk("R1", "rd_data", int'(rd_data), 0);
    chk("R1", "rd_tags", int'({rd_ferr, rd_perr}), 0);
  endtask

  task automatic t_order_tags();
    send(8'h11, 0, 0);
    expect_head("R2", 'h11, 0, 0);
    send(8'h22, 1, 0);
    expect_head("R5", 'h11, 0, 0);
    rd();
    expect_head("R5", 'h22, 1, 0);
    rd();
    chk("R2", "not_empty after drain", int'(not_empty), 0);
  endtask

  task automatic t_errors_continue();
    send(8'hA1, 0, 0);
    chk("R9", "err_pulse clean", int'(err_pulse), 0);
    send(8'hA2, 0, 1);
    chk("R9", "err_pulse tagged", int'(err_pulse), 1);
    cyc();
    chk("R9", "err_pulse one cycle", int'(err_pulse), 0);
    send(8'hA3, 1, 1);
    chk("R9", "err_pulse waiting tagged", int'(err_pulse), 1);
    expect_head("R6", 'hA1, 0, 0);
    rd();
    expect_head("R6", 'hA2, 0, 1);
    rd();
    expect_head("R6", 'hA3, 1, 1);
    rd();
    chk("R6", "empty", int'(not_empty), 0);
  endtask

  task automatic t_overflow();
    send(8'h31, 0, 0);
    send(8'h32, 1, 0);
    start_bit();
    chk("R3", "no ovf with two stored", int'(ovf_flag), 0);
    send(8'h33, 0, 1);
    start_bit();
    chk("R3", "ovf_flag", int'(ovf_flag), 1);
    chk("R9", "err_pulse on ovf", int'(err_pulse), 1);
    cyc();
    chk("R9", "err_pulse drops", int'(err_pulse), 0);
    chk("R8", "flag held without clear", int'(ovf_flag), 1);
    send(8'h34, 0, 0);
    chk("R9", "no err_pulse on drop", int'(err_pulse), 0);
    rd();
    expect_head("R5", 'h32, 1, 0);
    send(8'h35, 0, 0);
    clear_ovf();
    chk("R8", "ovf cleared", int'(ovf_flag), 0);
    send(8'h36, 0, 0);
    rd();
    expect_head("R10", 'h33, 0, 1);
    rd();
    expect_head("R4", 'h36, 0, 0);
    rd();
    chk("R4", "dropped chars absent", int'(not_empty), 0);
  endtask

  task automatic t_set_wins();
    send(8'h41, 0, 0);
    send(8'h42, 0, 0);
    send(8'h43, 0, 0);
    start_seen = 1'b1; ovf_clr = 1'b1;
    cyc();
    start_seen = 1'b0; ovf_clr = 1'b0;
    chk("R8", "set wins over clear", int'(ovf_flag), 1);
    clear_ovf();
    chk("R8", "clear later", int'(ovf_flag), 0);
    drain_to_empty();
  endtask

  task automatic t_full_drop();
    send(8'h51, 0, 0);
    send(8'h52, 0, 0);
    send(8'h53, 0, 0);
    send(8'h54, 1, 0);
    chk("R11", "ovf stays 0", int'(ovf_flag), 0);
    chk("R9", "no err_pulse dropped tagged", int'(err_pulse), 0);
    expect_head("R11", 'h51, 0, 0);
    rd();
    expect_head("R11", 'h52, 0, 0);
    rd();
    expect_head("R10", 'h53, 0, 0);
    rd();
    chk("R11", "fourth dropped", int'(not_empty), 0);
  endtask

  task automatic t_flush();
    send(8'h61, 0, 0);
    send(8'h62, 0, 0);
    send(8'h63, 0, 0);
    start_bit();
    chk("R3", "ovf before flush", int'(ovf_flag), 1);
    rx_en = 1'b0;
    cyc();
    chk("R7", "flushed empty", int'(not_empty), 0);
    chk("R7", "flushed ovf", int'(ovf_flag), 0);
    send(8'h64, 1, 0);
    start_bit();
    chk("R7", "ignored while off", int'(not_empty), 0);
    chk("R7", "no err_pulse while off", int'(err_pulse), 0);
    rx_en = 1'b1;
    cyc();
    chk("R7", "still empty after enable", int'(not_empty), 0);
    send(8'h65, 0, 0);
    expect_head("R7", 'h65, 0, 0);
    rd();
  endtask

  task automatic t_empty_read();
    rd();
    chk("R10", "read on empty", int'(not_empty), 0);
    send(8'h5A, 0, 0);
    expect_head("R10", 'h5A, 0, 0);
    rd();
    chk("R10", "empty again", int'(not_empty), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    cyc();
    t_reset();
    t_order_tags();
    t_errors_continue();
    t_overflow();
    t_set_wins();
    t_full_drop();
    t_flush();
    t_empty_read();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule